// File: doc/BRIEF.md
# DRAM Test Address Generator

This block is the address source that sits beside one command slot of a DRAM test sequencer. It keeps a row/column address, a bank address and a rank select in registers. Each time the sequencer issues a command for the slot, the generator may move these values on by a programmed rule. The rule can step the address by 1, 8 or both, step the bank by one, and step the rank by 1, 2 or 3. Address changes stay inside a low bit window whose top bit is programmable. A 23-bit maximal-length LFSR can overwrite part of that window to scramble the addresses.

A load strobe copies the slot configuration into the working registers, including the LFSR seed. A rate divider lets only every (N+1)-th issued command update the state. On cycles where the sequencer sends no command, a deselect mode picks what goes on the bus. The bus can carry the plain address, the address XORed with the LFSR, or the XORed address with the LFSR also advancing. The LFSR state is always visible on an output, so software can read it back when the sub-sequence ends. The DRAM command encoding is decided elsewhere.

Top module: `seq_addr_gen`

## Requirements
- R1: After reset, addr_o, bank_o and rank_o are zero and lfsr_o is 1.
- R2: A cycle with load high captures cfg_addr, cfg_bank and cfg_rank, and captures cfg_seed into the LFSR. A seed of 0 is stored as 1. All of these appear on the outputs after the next rising edge. The load also clears the rate counter.
- R3: An update adds (inc1 ? 1 : 0) + (inc8 ? 8 : 0) to the address. It adds bank_inc to the bank modulo 8 and adds rank_step (0..3) to the rank modulo 4.
- R4: An update changes only address bits [W:0], where W is cfg_wrap. Those bits wrap modulo 2^(W+1). For W >= 15 the whole 16-bit address wraps modulo 65536.
- R5: With cfg_rate = N, only every (N+1)-th issued command after a load performs an update. Issued commands in between leave every output unchanged.
- R6: The LFSR step is next = {s[21:0], s[22]^s[17]}, which is the polynomial x^23+x^18+1. Only an update in LFSR mode 2 or 3, or a deselect cycle in deselect mode 2, advances the LFSR by one step.
- R7: LFSR mode (cfg_lfsr_mode) 0 or 1 leaves the incremented address as it is. Mode 2 replaces address bits [W:0] with the same bits of the advanced LFSR. Mode 3 replaces only bits [W:3] and keeps bits [2:0] from the increment.
- R8: A deselect cycle is dsel_cycle high with cmd_issued and load low. On such a cycle, deselect mode (cfg_dsel_mode) 1 or 2 drives bus_addr_o = addr_o ^ lfsr_o[15:0] in the same cycle, and otherwise bus_addr_o = addr_o. Deselect cycles never change the address, bank, rank or rate counter. Only mode 2 advances the LFSR.
- R9: lfsr_o is never zero.
- R10: Load takes priority over cmd_issued, and cmd_issued takes priority over dsel_cycle. When a command and a deselect arrive together, the deselect is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Copy slot configuration into working state |
| cfg_addr | input | 16 | Start address |
| cfg_bank | input | 3 | Start bank |
| cfg_rank | input | 2 | Start rank |
| cfg_seed | input | 23 | LFSR seed |
| cfg_inc1 | input | 1 | Add 1 to address per update |
| cfg_inc8 | input | 1 | Add 8 to address per update |
| cfg_bank_inc | input | 1 | Add 1 to bank per update |
| cfg_rank_step | input | 2 | Rank step per update |
| cfg_wrap | input | 5 | Top bit W of the update window |
| cfg_lfsr_mode | input | 2 | LFSR scramble mode |
| cfg_rate | input | 4 | Update once per N+1 issued commands |
| cfg_dsel_mode | input | 2 | Deselect-cycle LFSR behaviour |
| cmd_issued | input | 1 | A slot command was issued this cycle |
| dsel_cycle | input | 1 | No command issued: deselect cycle |
| addr_o | output | 16 | Current address |
| bank_o | output | 3 | Current bank |
| rank_o | output | 2 | Current rank |
| lfsr_o | output | 23 | Current LFSR state for readback |
| bus_addr_o | output | 16 | Address as driven on the bus this cycle |

## Verification
The registered results (addr_o, bank_o, rank_o, lfsr_o) are due one rising edge after the cycle that carries the load, command or deselect. bus_addr_o is combinational and is due in the same cycle as dsel_cycle. The bench drives inputs on the falling edge and checks bus_addr_o 1 ns later. It then waits for the next falling edge, after exactly one rising edge, to compare the registered outputs against its own model. The model tracks the rate counter itself, so throttled commands are checked to leave the state unchanged in the cycle they occur.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BANK_W = 3;
  localparam int unsigned RANK_W = 2;
  localparam int unsigned LFSR_W = 23;
  localparam int unsigned TAP_HI = 22;
  localparam int unsigned TAP_LO = 17;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned WRAP_W = $clog2(ADDR_W) + 1;
  localparam int unsigned KEEP_LO = 3;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [LFSR_W-1:0] lfsr_t;
  typedef logic [WRAP_W-1:0] wrap_t;

  typedef enum logic [1:0] {LM_OFF = 2'd0, LM_RSVD = 2'd1, LM_FULL = 2'd2, LM_HIGH = 2'd3} lfsr_mode_e;
  typedef enum logic [1:0] {DS_HOLD = 2'd0, DS_XOR = 2'd1, DS_XOR_ADV = 2'd2, DS_RSVD = 2'd3} dsel_mode_e;

  // One step of the Fibonacci register; all-zeros is pushed back to 1.
  function automatic lfsr_t lfsr_step(lfsr_t s);
    lfsr_t n;
    n = {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
    if (n == '0) n = lfsr_t'(1);
    return n;
  endfunction

  // Bits [w:0] set; w past the top covers the whole address.
  function automatic addr_t span_mask(wrap_t w);
    addr_t m;
    for (int i = 0; i < ADDR_W; i++) m[i] = (i <= int'(w));
    return m;
  endfunction
endpackage

// File: rtl/sag_rate_div.sv
module sag_rate_div
  import sag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              fire
);
  logic [RATE_W-1:0] cnt_q;

  assign fire = tick && (cnt_q == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= fire ? '0 : cnt_q + 1'b1;
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(clear)) |-> cnt_q == $past(cnt_q));
endmodule

// File: rtl/sag_lfsr.sv
module sag_lfsr
  import sag_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  lfsr_t seed,
  input  logic  advance,
  output lfsr_t state_o,
  output lfsr_t next_o
);
  lfsr_t state_q;

  assign next_o  = lfsr_step(state_q);
  assign state_o = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= lfsr_t'(1);
    else if (load)    state_q <= (seed == '0) ? lfsr_t'(1) : seed;
    else if (advance) state_q <= next_o;
  end

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(advance)) |-> $stable(state_q));
endmodule

// File: rtl/sag_addr_next.sv
module sag_addr_next
  import sag_pkg::*;
(
  input  addr_t             addr,
  input  logic [BANK_W-1:0] bank,
  input  logic [RANK_W-1:0] rank,
  input  logic              inc1,
  input  logic              inc8,
  input  logic              bank_inc,
  input  logic [RANK_W-1:0] rank_step,
  input  wrap_t             wrap,
  input  logic [1:0]        lmode,
  input  lfsr_t             lfsr_new,
  output addr_t             addr_n,
  output logic [BANK_W-1:0] bank_n,
  output logic [RANK_W-1:0] rank_n,
  output addr_t             win_mask
);
  addr_t inc, summed, stepped, scr_mask;

  always_comb begin
    win_mask = span_mask(wrap);
    inc      = (inc1 ? addr_t'(1) : '0) + (inc8 ? addr_t'(8) : '0);
    summed   = addr + inc;
    stepped  = (addr & ~win_mask) | (summed & win_mask);
    unique case (lfsr_mode_e'(lmode))
      LM_FULL: scr_mask = win_mask;
      LM_HIGH: scr_mask = win_mask & ~addr_t'((1 << KEEP_LO) - 1);
      default: scr_mask = '0;
    endcase
    addr_n = (stepped & ~scr_mask) | (lfsr_new[ADDR_W-1:0] & scr_mask);
    bank_n = bank + BANK_W'(bank_inc);
    rank_n = rank + rank_step;
  end
endmodule

// File: rtl/seq_addr_gen.sv
module seq_addr_gen
  import sag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [RANK_W-1:0] cfg_rank,
  input  logic [LFSR_W-1:0] cfg_seed,
  input  logic              cfg_inc1,
  input  logic              cfg_inc8,
  input  logic              cfg_bank_inc,
  input  logic [RANK_W-1:0] cfg_rank_step,
  input  logic [WRAP_W-1:0] cfg_wrap,
  input  logic [1:0]        cfg_lfsr_mode,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [1:0]        cfg_dsel_mode,
  input  logic              cmd_issued,
  input  logic              dsel_cycle,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [RANK_W-1:0] rank_o,
  output logic [LFSR_W-1:0] lfsr_o,
  output logic [ADDR_W-1:0] bus_addr_o
);
  addr_t             addr_q, addr_n, win_mask;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [RANK_W-1:0] rank_q, rank_n;
  lfsr_t             lfsr_q, lfsr_nx;
  logic              cmd_tick, upd_fire, dsel_only, dsel_xor, lfsr_adv;

  // Named internal events
  assign cmd_tick  = cmd_issued && !load;
  assign dsel_only = dsel_cycle && !cmd_issued && !load;
  assign dsel_xor  = dsel_only && (dsel_mode_e'(cfg_dsel_mode) inside {DS_XOR, DS_XOR_ADV});
  assign lfsr_adv  = (upd_fire && cfg_lfsr_mode[1]) ||
                     (dsel_only && dsel_mode_e'(cfg_dsel_mode) == DS_XOR_ADV);

  sag_rate_div u_rate (
    .clk(clk), .rst_n(rst_n), .clear(load), .tick(cmd_tick),
    .rate(cfg_rate), .fire(upd_fire)
  );

  sag_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(load), .seed(cfg_seed),
    .advance(lfsr_adv), .state_o(lfsr_q), .next_o(lfsr_nx)
  );

  sag_addr_next u_next (
    .addr(addr_q), .bank(bank_q), .rank(rank_q),
    .inc1(cfg_inc1), .inc8(cfg_inc8), .bank_inc(cfg_bank_inc),
    .rank_step(cfg_rank_step), .wrap(cfg_wrap), .lmode(cfg_lfsr_mode),
    .lfsr_new(lfsr_nx), .addr_n(addr_n), .bank_n(bank_n), .rank_n(rank_n),
    .win_mask(win_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bank_q <= '0;
      rank_q <= '0;
    end else if (load) begin
      addr_q <= cfg_addr;
      bank_q <= cfg_bank;
      rank_q <= cfg_rank;
    end else if (upd_fire) begin
      addr_q <= addr_n;
      bank_q <= bank_n;
      rank_q <= rank_n;
    end
  end

  assign addr_o     = addr_q;
  assign bank_o     = bank_q;
  assign rank_o     = rank_q;
  assign lfsr_o     = lfsr_q;
  assign bus_addr_o = dsel_xor ? (addr_q ^ lfsr_q[ADDR_W-1:0]) : addr_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (addr_q == $past(cfg_addr) && bank_q == $past(cfg_bank)
                     && rank_q == $past(cfg_rank)));

  // R4
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_fire) && !$past(load)) |-> ((addr_q ^ $past(addr_q)) & ~$past(win_mask)) == '0);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && !$past(upd_fire)) |-> (addr_q == $past(addr_q) && bank_q == $past(bank_q)
                                            && rank_q == $past(rank_q)));

  // R10
  cmd_over_dsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issued && dsel_cycle) |-> bus_addr_o == addr_o);
endmodule

// File: tb/seq_addr_gen_bench.sv
`timescale 1ns/1ps
module seq_addr_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 0, cmd_issued = 0, dsel_cycle = 0;
  logic [15:0] cfg_addr = 0;
  logic [2:0]  cfg_bank = 0;
  logic [1:0]  cfg_rank = 0, cfg_rank_step = 0, cfg_lfsr_mode = 0, cfg_dsel_mode = 0;
  logic [22:0] cfg_seed = 0;
  logic        cfg_inc1 = 0, cfg_inc8 = 0, cfg_bank_inc = 0;
  logic [4:0]  cfg_wrap = 0;
  logic [3:0]  cfg_rate = 0;
  logic [15:0] addr_o, bus_addr_o;
  logic [2:0]  bank_o;
  logic [1:0]  rank_o;
  logic [22:0] lfsr_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int m_addr, m_bank, m_rank, m_lfsr, m_cnt;

  always #2 clk = ~clk;

  seq_addr_gen u_seq_addr_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .cfg_addr(cfg_addr), .cfg_bank(cfg_bank),
    .cfg_rank(cfg_rank), .cfg_seed(cfg_seed), .cfg_inc1(cfg_inc1), .cfg_inc8(cfg_inc8),
    .cfg_bank_inc(cfg_bank_inc), .cfg_rank_step(cfg_rank_step), .cfg_wrap(cfg_wrap),
    .cfg_lfsr_mode(cfg_lfsr_mode), .cfg_rate(cfg_rate), .cfg_dsel_mode(cfg_dsel_mode),
    .cmd_issued(cmd_issued), .dsel_cycle(dsel_cycle), .addr_o(addr_o), .bank_o(bank_o),
    .rank_o(rank_o), .lfsr_o(lfsr_o), .bus_addr_o(bus_addr_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int b_lfsr(int s);
    int fb = ((s >> 22) ^ (s >> 17)) & 1;
    return ((s << 1) | fb) & 32'h7fffff;
  endfunction

  // Model of one update (R3, R4, R7)
  task automatic model_update();
    int span = (cfg_wrap >= 15) ? 65536 : (1 << (cfg_wrap + 1));
    int inc  = (cfg_inc1 ? 1 : 0) + (cfg_inc8 ? 8 : 0);
    int low  = ((m_addr % span) + inc) % span;
    m_addr = m_addr - (m_addr % span) + low;
    m_bank = (m_bank + cfg_bank_inc) % 8;
    m_rank = (m_rank + cfg_rank_step) % 4;
    if (cfg_lfsr_mode >= 2) begin
      int top = (cfg_wrap > 15) ? 15 : cfg_wrap;
      m_lfsr = b_lfsr(m_lfsr);
      for (int b = (cfg_lfsr_mode == 3) ? 3 : 0; b <= top; b++)
        m_addr = (m_addr & ~(1 << b)) | (m_lfsr & (1 << b));
    end
  endtask

  task automatic step(bit ld, bit cmd, bit ds);
    string tag;
    int exp_bus;
    bit upd;
    load = ld; cmd_issued = cmd; dsel_cycle = ds;
    #1;
    // R8 / R10: combinational bus address in the same cycle
    exp_bus = (ds && !cmd && !ld && (cfg_dsel_mode == 1 || cfg_dsel_mode == 2))
              ? (m_addr ^ (m_lfsr & 16'hffff)) : m_addr;
    chk((cmd && ds) ? "R10" : "R8", "bus_addr", bus_addr_o, exp_bus);
    upd = 0;
    if (ld) begin
      m_addr = cfg_addr; m_bank = cfg_bank; m_rank = cfg_rank;
      m_lfsr = (cfg_seed == 0) ? 1 : cfg_seed; m_cnt = 0;
      tag = cmd ? "R10" : "R2";
    end else if (cmd) begin
      if (m_cnt == cfg_rate) begin upd = 1; m_cnt = 0; model_update(); end
      else m_cnt = (m_cnt + 1) % 16;
      tag = !upd ? "R5" : (cfg_lfsr_mode >= 2) ? "R7" : "R3";
    end else begin
      if (ds && cfg_dsel_mode == 2) m_lfsr = b_lfsr(m_lfsr);
      tag = "R8";
    end
    @(negedge clk);
    chk(tag, "addr", addr_o, m_addr);
    chk(tag, "bank", bank_o, m_bank);
    chk(tag, "rank", rank_o, m_rank);
    chk(tag, "lfsr", lfsr_o, m_lfsr);
    chk("R9", "lfsr_nonzero", (lfsr_o != 0), 1);
    load = 0; cmd_issued = 0; dsel_cycle = 0;
  endtask

  task automatic rand_cfg();
    cfg_addr = 16'($urandom); cfg_bank = 3'($urandom); cfg_rank = 2'($urandom);
    cfg_seed = ($urandom % 8 == 0) ? 23'd0 : 23'($urandom);
    cfg_inc1 = 1'($urandom); cfg_inc8 = 1'($urandom); cfg_bank_inc = 1'($urandom);
    cfg_rank_step = 2'($urandom); cfg_wrap = 5'($urandom);
    cfg_lfsr_mode = 2'($urandom); cfg_rate = 4'($urandom % 4);
    cfg_dsel_mode = 2'($urandom);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    m_addr = 0; m_bank = 0; m_rank = 0; m_lfsr = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "addr", addr_o, 0); chk("R1", "bank", bank_o, 0);
    chk("R1", "rank", rank_o, 0); chk("R1", "lfsr", lfsr_o, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: zero seed becomes 1; R3/R4 wrap of low window
    cfg_addr = 16'hABC7; cfg_bank = 3'd7; cfg_rank = 2'd3; cfg_seed = 23'd0;
    cfg_inc1 = 1; cfg_inc8 = 0; cfg_bank_inc = 1; cfg_rank_step = 2'd2;
    cfg_wrap = 5'd2; cfg_lfsr_mode = 2'd0; cfg_rate = 4'd0; cfg_dsel_mode = 2'd0;
    step(1, 0, 0);
    chk("R2", "seed0", lfsr_o, 1);
    step(0, 1, 0);
    chk("R4", "wrap literal", addr_o, 16'hABC0);
    chk("R3", "bank literal", bank_o, 0);
    chk("R3", "rank literal", rank_o, 1);

    // R6/R7: one LFSR step from bit 22 gives 1, written into bits [3:0]
    cfg_addr = 16'h0000; cfg_seed = 23'h400000; cfg_inc1 = 0; cfg_wrap = 5'd3;
    cfg_lfsr_mode = 2'd2;
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R6", "lfsr literal", lfsr_o, 1);
    chk("R7", "scramble literal", addr_o, 16'h0001);

    // R7 mode 3 keeps bits [2:0]; R5 rate 2
    cfg_addr = 16'h0005; cfg_seed = 23'h7FFFFF; cfg_inc8 = 1; cfg_wrap = 5'd15;
    cfg_lfsr_mode = 2'd3; cfg_rate = 4'd2;
    step(1, 0, 0);
    step(0, 1, 0); step(0, 1, 0);
    chk("R5", "throttled", addr_o, 16'h0005);
    step(0, 1, 0);

    // R8 deselect modes, R10 command with deselect
    for (int md = 0; md < 4; md++) begin
      cfg_dsel_mode = 2'(md);
      step(0, 0, 1);
      step(0, 1, 1);
    end

    // Random phases
    for (int ph = 0; ph < 60; ph++) begin
      rand_cfg();
      step(1, 1'($urandom), 0);
      for (int c = 0; c < 30; c++)
        step(0, ($urandom % 2) == 0, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule